// File: doc/BRIEF.md
# Buffered SPI Slave Shifter

This block is a byte-wide SPI slave for serial clock modes 0 and 1, with the clock idling low in both. It has a transmit holding buffer, one shift register used for both directions, and a receive holding buffer, so firmware can queue the next outgoing byte and collect the last incoming byte while the current byte shifts. The serial pins (clock, select, data in) pass through a synchroniser and are edge-detected on the host clock. All timing of a transfer comes from the serial clock edges.

Firmware uses a two-address register port. Address 0 writes the control bits and reads them back together with three status flags; reading address 0 clears the transfer-complete flag. Address 1 writes the transmit buffer and reads the receive buffer. A force bit lets firmware assert select without the pin. The data output idles high whenever the block is not both enabled and selected. The auxiliary pad is never driven. The interrupt follows transfer-complete when its enable bit is set.

A control FSM has three states. OFF is the state while disabled. OFF goes to ARMED on enable. ARMED goes to ACTIVE when select is asserted, and loads the transmit buffer. ACTIVE goes back to ARMED on deselect, which aborts the byte. Every state goes to OFF when enable is cleared. Within ACTIVE a bit counter sorts serial edges into sample edges and drive edges.

Top module: `spi_slave_shifter`

## Requirements
- R1: After reset the status read at address 0 is 8'h20 (only transmit-empty set), irq is 0 and miso is 1 even with ss_n low, because enable is clear.
- R2: miso carries data only while the enable bit (control bit 0) is 1 and select is active; when enabled but deselected, miso is 1.
- R3: Control bit 2 (force select) acts as an active select with ss_n high: the transmit buffer is loaded and a full byte transfers.
- R4: Control bit 7 picks the bit order: 1 sends and receives the least significant bit first (miso shows shift-register bit 0), 0 sends the most significant bit first.
- R5: aux_oe is always 0, so the auxiliary pad stays high impedance.
- R6: Clearing enable forces miso to 1 and resets the status to transmit-empty=1, receive-full=0, complete=0. The transmit buffer, shift register and receive buffer keep their contents.
- R7: When select becomes active, the transmit buffer is copied into the shift register and its first bit appears on miso at once. Transmit-empty (status bit 5) is set by that load and cleared by a write to address 1.
- R8: When the last bit of a byte is sampled, the byte goes to the receive buffer and receive-full (bit 6) and complete (bit 4) are set. irq equals complete AND interrupt-enable (control bit 3).
- R9: Control bit 1 selects the mode. In mode 0, mosi is sampled on rising sclk and data shifts on falling sclk. In mode 1, data shifts on rising sclk and mosi is sampled on falling sclk, and the first rising edge after select does not shift.
- R10: Reading address 1 clears receive-full; reading address 0 clears complete.
- R11: If the transmit buffer is still empty when a new byte starts, the block resends the buffer's previous contents and sets no extra status bit.
- R12: Deasserting select mid-byte sets miso to 1, leaves the receive buffer and flags unchanged, and the next selection starts again at bit 0.
- R13: With select held, consecutive bytes follow with no gap. A byte written during the current transfer is sent as the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (read side effects) |
| host_addr | input | 2 | Register address: 0 control/status, 1 data |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data (combinational) |
| sclk | input | 1 | Serial clock from master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, idles high |
| aux_oe | output | 1 | Auxiliary pad drive enable, held 0 |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench checks both modes in both bit orders. For mode 0 with MSB first it sends all 256 transmit values. It checks that the first bit is on miso as soon as select falls. A design that loaded on the first clock edge would show stale data here, and one that shifted on the first mode-1 rising edge would lose the top bit. Back-to-back bytes with a late write, and a third byte with no write, show that the queued byte is used and that an empty buffer is resent with no extra flag. Further cases cover a mid-byte deselect, a disable with data pending (status must clear while both buffers survive) and a forced select with the interrupt masked. These catch designs that commit partial bytes, wipe the buffers, or assert irq regardless of its enable.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } slv_state_e;

    // control bit positions (address 0 write/read)
    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_PHASE = 1;
    localparam int unsigned CTL_FORCE = 2;
    localparam int unsigned CTL_IRQEN = 3;
    localparam int unsigned CTL_LSBF  = 7;

    // status bit positions (address 0 read)
    localparam int unsigned STA_DONE  = 4;
    localparam int unsigned STA_TXE   = 5;
    localparam int unsigned STA_RXF   = 6;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_slv_fsm.sv
module spi_slv_fsm
    import spi_slv_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       phase,
    input  logic       select,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    output slv_state_e state,
    output logic       load,
    output logic       shift,
    output logic       sample,
    output logic       complete
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    slv_state_e       state_n;
    logic [CNT_W-1:0] bit_cnt, cnt_n;
    logic             fresh, fresh_n;
    logic             drive_edge, samp_edge;

    assign drive_edge = phase ? sclk_rise : sclk_fall;
    assign samp_edge  = phase ? sclk_fall : sclk_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            bit_cnt <= '0;
            fresh   <= 1'b0;
        end else begin
            state   <= state_n;
            bit_cnt <= cnt_n;
            fresh   <= fresh_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = bit_cnt;
        fresh_n = fresh;
        unique case (state)
            ST_OFF: begin
                cnt_n   = '0;
                fresh_n = 1'b0;
                if (enable) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (!enable) begin
                    state_n = ST_OFF;
                end else if (select) begin
                    state_n = ST_ACTIVE;
                    cnt_n   = '0;
                    fresh_n = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (!enable) begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                    fresh_n = 1'b0;
                end else if (!select) begin
                    state_n = ST_ARMED;
                    cnt_n   = '0;
                    fresh_n = 1'b0;
                end else begin
                    if (samp_edge) begin
                        fresh_n = 1'b0;
                        cnt_n   = (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
                    end
                    if (drive_edge && bit_cnt == '0 && phase && fresh)
                        fresh_n = 1'b0;
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    // output strobes
    always_comb begin
        load     = 1'b0;
        shift    = 1'b0;
        sample   = 1'b0;
        complete = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_ARMED: load = enable && select;
            ST_ACTIVE: begin
                if (enable && select) begin
                    if (samp_edge) begin
                        sample   = 1'b1;
                        complete = (bit_cnt == LAST);
                    end
                    if (drive_edge) begin
                        if (bit_cnt == '0) load  = !(phase && fresh);
                        else               shift = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // R12
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> (bit_cnt == '0));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, shift, sample}));

endmodule

// File: rtl/spi_slv_shreg.sv
module spi_slv_shreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              sample,
    input  logic              lsb_first,
    input  logic              mosi,
    input  logic [DATA_W-1:0] tx_word,
    output logic              out_bit,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] sr;
    logic              held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            held <= 1'b0;
        end else begin
            if (load)
                sr <= tx_word;
            else if (shift)
                sr <= lsb_first ? {held, sr[DATA_W-1:1]} : {sr[DATA_W-2:0], held};
            if (sample)
                held <= mosi;
        end
    end

    // the final bit is taken straight from the line on the completing edge
    assign rx_word = lsb_first ? {mosi, sr[DATA_W-1:1]} : {sr[DATA_W-2:0], mosi};
    assign out_bit = lsb_first ? sr[0] : sr[DATA_W-1];

endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter
    import spi_slv_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sclk,
    input  logic              ss_n,
    input  logic              mosi,
    output logic              miso,
    output logic              aux_oe,
    output logic              irq
);

    logic [2:0] pins_s;
    logic       sclk_s, ss_n_s, mosi_s, sclk_d;
    logic       sclk_rise, sclk_fall, select;

    logic ctl_en, ctl_phase, ctl_force, ctl_irqen, ctl_lsbf;
    logic txe, rxf, done;
    logic [DATA_W-1:0] tx_buf, rx_buf, rx_word;
    logic ctl_wr, tx_wr, rx_rd, st_rd;
    logic load, shift, sample, complete, out_bit;
    slv_state_e state;

    spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, ss_n, mosi}), .q(pins_s));

    assign {sclk_s, ss_n_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign select    = ~ss_n_s | ctl_force;

    assign ctl_wr = host_wr && host_addr == ADDR_CTL;
    assign tx_wr  = host_wr && host_addr == ADDR_DATA;
    assign st_rd  = host_rd && host_addr == ADDR_CTL;
    assign rx_rd  = host_rd && host_addr == ADDR_DATA;

    spi_slv_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(ctl_en), .phase(ctl_phase),
        .select(select), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .state(state), .load(load), .shift(shift), .sample(sample),
        .complete(complete));

    spi_slv_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .sample(sample),
        .lsb_first(ctl_lsbf), .mosi(mosi_s), .tx_word(tx_buf),
        .out_bit(out_bit), .rx_word(rx_word));

    // control bits and data buffers: untouched by disable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_phase <= 1'b0;
            ctl_force <= 1'b0;
            ctl_irqen <= 1'b0;
            ctl_lsbf  <= 1'b0;
            tx_buf    <= '0;
            rx_buf    <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_en    <= host_wdata[CTL_EN];
                ctl_phase <= host_wdata[CTL_PHASE];
                ctl_force <= host_wdata[CTL_FORCE];
                ctl_irqen <= host_wdata[CTL_IRQEN];
                ctl_lsbf  <= host_wdata[CTL_LSBF];
            end
            if (tx_wr)    tx_buf <= host_wdata;
            if (complete) rx_buf <= rx_word;
        end
    end

    // status flags: held at reset value while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe  <= 1'b1;
            rxf  <= 1'b0;
            done <= 1'b0;
        end else if (!ctl_en) begin
            txe  <= 1'b1;
            rxf  <= 1'b0;
            done <= 1'b0;
        end else begin
            if (load)     txe  <= 1'b1;
            if (tx_wr)    txe  <= 1'b0;
            if (rx_rd)    rxf  <= 1'b0;
            if (complete) rxf  <= 1'b1;
            if (st_rd)    done <= 1'b0;
            if (complete) done <= 1'b1;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_CTL: begin
                host_rdata[CTL_EN]    = ctl_en;
                host_rdata[CTL_PHASE] = ctl_phase;
                host_rdata[CTL_FORCE] = ctl_force;
                host_rdata[CTL_IRQEN] = ctl_irqen;
                host_rdata[STA_DONE]  = done;
                host_rdata[STA_TXE]   = txe;
                host_rdata[STA_RXF]   = rxf;
                host_rdata[CTL_LSBF]  = ctl_lsbf;
            end
            ADDR_DATA: host_rdata = rx_buf;
            default:   host_rdata = '0;
        endcase
    end

    assign miso   = (state == ST_ACTIVE) ? out_bit : 1'b1;
    assign irq    = done & ctl_irqen;
    assign aux_oe = 1'b0;

    // R2
    miso_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> miso);

    // R6
    rx_keep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> $stable(rx_buf));

    // R8
    complete_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (rxf && done));

    // R7
    load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !tx_wr) |=> txe);

    // R10
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !complete && ctl_en) |=> !rxf);

endmodule

// File: tb/spi_slave_shifter_test.sv
module spi_slave_shifter_test;

    localparam int HALF  = 8;
    localparam int LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso, aux_oe, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    spi_slave_shifter uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
        .aux_oe(aux_oe), .irq(irq));

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            errors++;
            $display("FAIL watchdog all actual=%0d expected<%0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input logic ph, input logic lf,
                                       input logic frc, input logic ie);
        return {lf, 3'b000, ie, frc, ph, 1'b1};
    endfunction

    // master side of nb bits; bit i of the frame is word bit (lf ? i : 7-i)
    task automatic shift_bits(input logic ph, input logic lf, input logic [7:0] mo,
                              input int nb, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < nb; i++) begin
            int idx = lf ? i : 7 - i;
            if (ph) sclk = 1'b1;
            mosi = mo[idx];
            wait_clk(HALF);
            mi[idx] = miso;
            sclk = ph ? 1'b0 : 1'b1;
            wait_clk(HALF);
            if (!ph) sclk = 1'b0;
        end
        wait_clk(HALF);
    endtask

    logic [7:0] st, rx, mi, t, r, last_rx;

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 R5 reset state
        host_read(2'd0, st);
        chk("R1 reset status", st, 8'h20);
        chk("R1 irq after reset", irq, 1'b0);
        chk("R5 aux_oe", aux_oe, 1'b0);
        ss_n = 1'b0; wait_clk(HALF);
        chk("R1 miso idle while disabled", miso, 1'b1);
        ss_n = 1'b1;

        host_write(2'd0, ctl(0, 0, 0, 1));
        wait_clk(HALF);
        chk("R2 miso idle enabled unselected", miso, 1'b1);

        // sweep: R4 R7 R8 R9 R10
        for (int cfg = 0; cfg < 4; cfg++) begin
            logic ph = cfg[0];
            logic lf = cfg[1];
            int n = (cfg == 0) ? 256 : 16;
            for (int k = 0; k < n; k++) begin
                t = (cfg == 0) ? 8'(k) : (8'(k * 17) ^ 8'h3C);
                r = {t[3:0], t[7:4]} ^ 8'h96;
                host_write(2'd0, ctl(ph, lf, 0, 1));
                host_write(2'd1, t);
                host_read(2'd0, st);
                chk("R7 write clears tx-empty", st[5], 1'b0);
                ss_n = 1'b0;
                wait_clk(HALF);
                chk("R7 first bit at select", miso, lf ? t[0] : t[7]);
                shift_bits(ph, lf, r, 8, mi);
                chk("R9 R4 miso byte", mi, t);
                chk("R8 irq on complete", irq, 1'b1);
                host_read(2'd0, st);
                chk("R8 status after byte", st[6:4], 3'b111);
                host_read(2'd0, st);
                chk("R10 status read clears complete", st[4], 1'b0);
                chk("R10 irq drops", irq, 1'b0);
                host_read(2'd1, rx);
                chk("R8 R9 rx byte", rx, r);
                host_read(2'd0, st);
                chk("R10 rx read clears rx-full", st[6], 1'b0);
                ss_n = 1'b1;
                wait_clk(HALF);
                last_rx = r;
            end
        end

        // R13 R11 back-to-back, then empty buffer
        for (int ph = 0; ph < 2; ph++) begin
            logic lf = ph[0];
            host_write(2'd0, ctl(ph[0], lf, 0, 1));
            host_write(2'd1, 8'hC3);
            ss_n = 1'b0;
            wait_clk(HALF);
            host_read(2'd0, st);
            chk("R7 load sets tx-empty", st[5], 1'b1);
            host_write(2'd1, 8'h5E);
            host_read(2'd0, st);
            chk("R7 queued write clears tx-empty", st[5], 1'b0);
            shift_bits(ph[0], lf, 8'h11, 8, mi);
            chk("R13 first byte", mi, 8'hC3);
            host_read(2'd1, rx);
            chk("R13 first rx", rx, 8'h11);
            shift_bits(ph[0], lf, 8'h22, 8, mi);
            chk("R13 queued byte sent", mi, 8'h5E);
            host_read(2'd1, rx);
            chk("R13 second rx", rx, 8'h22);
            shift_bits(ph[0], lf, 8'h33, 8, mi);
            chk("R11 resend on empty", mi, 8'h5E);
            host_read(2'd0, st);
            chk("R11 no extra flag", st, {lf, 3'b111, 1'b1, 1'b0, ph[0], 1'b1});
            host_read(2'd1, rx);
            chk("R11 third rx", rx, 8'h33);
            ss_n = 1'b1;
            wait_clk(HALF);
            last_rx = 8'h33;
        end

        // R12 abort mid-byte
        host_write(2'd0, ctl(0, 0, 0, 1));
        host_read(2'd0, st);
        host_write(2'd1, 8'hF0);
        ss_n = 1'b0;
        wait_clk(HALF);
        shift_bits(1'b0, 1'b0, 8'hA5, 3, mi);
        ss_n = 1'b1;
        wait_clk(HALF);
        chk("R12 miso idle after abort", miso, 1'b1);
        host_read(2'd0, st);
        chk("R12 no flags after abort", st[6:4], 3'b010);
        host_read(2'd1, rx);
        chk("R12 rx unchanged", rx, last_rx);
        host_write(2'd1, 8'h0F);
        ss_n = 1'b0;
        wait_clk(HALF);
        shift_bits(1'b0, 1'b0, 8'hAB, 8, mi);
        chk("R12 restart tx", mi, 8'h0F);
        host_read(2'd1, rx);
        chk("R12 restart rx", rx, 8'hAB);
        ss_n = 1'b1;
        wait_clk(HALF);

        // R3 force select, R8 masked irq
        host_write(2'd1, 8'h7E);
        host_write(2'd0, ctl(0, 0, 1, 0));
        wait_clk(HALF);
        chk("R3 forced first bit", miso, 1'b0);
        shift_bits(1'b0, 1'b0, 8'h3C, 8, mi);
        chk("R3 forced byte", mi, 8'h7E);
        chk("R8 irq masked", irq, 1'b0);
        host_read(2'd0, st);
        chk("R8 complete while masked", st[4], 1'b1);
        host_write(2'd0, ctl(0, 0, 0, 0));
        wait_clk(HALF);
        chk("R2 release force idles miso", miso, 1'b1);

        // R6 disable keeps data, clears status
        host_write(2'd1, 8'h6D);
        host_write(2'd0, 8'h00);
        wait_clk(2);
        host_read(2'd0, st);
        chk("R6 status after disable", st, 8'h20);
        ss_n = 1'b0;
        wait_clk(HALF);
        chk("R6 miso idle disabled", miso, 1'b1);
        chk("R5 aux_oe later", aux_oe, 1'b0);
        host_read(2'd1, rx);
        chk("R6 rx kept", rx, 8'h3C);
        ss_n = 1'b1;
        host_write(2'd0, ctl(0, 0, 0, 0));
        wait_clk(HALF);
        host_read(2'd0, st);
        chk("R6 status on re-enable", st, 8'h21);
        ss_n = 1'b0;
        wait_clk(HALF);
        shift_bits(1'b0, 1'b0, 8'h99, 8, mi);
        chk("R6 tx kept across disable", mi, 8'h6D);
        ss_n = 1'b1;
        wait_clk(HALF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule